// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block is a 16-tap finite impulse response filter for 16-bit two's-complement samples. It forms each output without any multiplier. A new sample shifts into a delay line. The block then walks the sixteen bit planes of the stored samples, one plane per clock. For each plane it sums the coefficients whose sample has that bit set, and it shift-accumulates these plane sums into a wide accumulator. The plane sums are computed on the fly from the live coefficient registers, with no lookup table, so the coefficients may be rewritten between any two samples.

Coefficients are written through a simple address/data port into a staging bank at any time. The staging bank is copied into the working bank only when a sample is accepted, so a computation always runs on one consistent coefficient set. A result takes 17 clocks. At a 20 MHz clock and a 100 kHz sample rate, 200 clocks are available per sample.

The controller has three states. In `ST_IDLE` it waits for a sample, and accepting a sample moves it to `ST_PLANE`. `ST_PLANE` stays for 16 clocks, and after the last plane it moves to `ST_EMIT`. `ST_EMIT` always returns to `ST_IDLE` after one clock.

Top module: `fda_fir`

## Requirements
- R1: After reset `out_valid` is 0, `out_sample` is 0, and every stored sample and coefficient is zero. A sample filtered with no coefficient ever written gives 0.
- R2: A coefficient at address k weights the sample accepted k acceptances earlier (address 0 weights the newest). Both coefficients and samples are 16-bit two's complement.
- R3: The result is defined as follows. Let P_j be the sum of the coefficients whose sample has bit j set. Start with A = 0. For j = 0 to 14, set A = floor((A + 16*P_j)/2). Then set A = A - 16*P_15. Bit 15 is the sign bit, so its plane is subtracted.
- R4: The output is floor((A + 8)/16). Exact halves therefore round toward plus infinity: 0.5 LSB gives 1, and -0.5 LSB gives 0.
- R5: The output saturates to the range -32768..32767.
- R6: `out_valid` is high for exactly one clock. That clock follows the 17th rising edge after the edge that accepted the sample.
- R7: `in_valid` seen at the 17 edges after an accepting edge is ignored, and that sample never enters the delay line. A sample presented while `out_valid` is high is accepted.
- R8: A coefficient write takes effect from the next accepted sample. A write at the accepting edge itself, or during a computation, does not affect the result in progress.
- R9: `out_sample` changes only at the edge that raises `out_valid`, and it holds between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe; accepted only when idle |
| in_sample | input | 16 | Input sample, two's complement |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 4 | Coefficient address (tap index) |
| coef_data | input | 16 | Coefficient value, two's complement |
| out_valid | output | 1 | One-clock result strobe |
| out_sample | output | 16 | Filtered sample, rounded and saturated |

## Verification
A coefficient write and a sample acceptance can land on the same clock edge. The bench provokes this by raising `coef_we` and `in_valid` together. It also provokes a second write in the middle of the `ST_PLANE` walk. Each result is judged against a model that applies the old coefficient set to that sample and the new value only to the next one. The bench also holds `in_valid` high through a whole computation, so an ignored strobe overlaps the plane walk and the emit clock. A later result then shows that the ignored sample never entered the delay line.

// File: rtl/fda_pkg.sv
package fda_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PLANE = 2'd1,
        ST_EMIT  = 2'd2
    } fda_state_t;
endpackage

// File: rtl/fda_delay_line.sv
module fda_delay_line #(
    parameter int TAPS = 16,
    parameter int DW   = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           shift_en,
    input  logic [DW-1:0]                  din,
    output logic [TAPS-1:0][DW-1:0]        taps
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            taps <= '0;
        else if (shift_en)
            taps <= {taps[TAPS-2:0], din};
    end
endmodule

// File: rtl/fda_coef_bank.sv
module fda_coef_bank #(
    parameter int TAPS = 16,
    parameter int CW   = 16,
    localparam int AW  = $clog2(TAPS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [CW-1:0]           wdata,
    input  logic                    commit,
    output logic [TAPS-1:0][CW-1:0] active
);
    logic [TAPS-1:0][CW-1:0] staged;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= '0;
            active <= '0;
        end else begin
            if (commit)
                active <= staged;
            for (int k = 0; k < TAPS; k++)
                if (we && waddr == AW'(k))
                    staged[k] <= wdata;
        end
    end
endmodule

// File: rtl/fda_plane_sum.sv
module fda_plane_sum #(
    parameter int TAPS = 16,
    parameter int DW   = 16,
    parameter int CW   = 16,
    localparam int PW  = $clog2(DW),
    localparam int PSW = CW + $clog2(TAPS) + 1
) (
    input  logic [TAPS-1:0][DW-1:0] taps,
    input  logic [TAPS-1:0][CW-1:0] coefs,
    input  logic [PW-1:0]           plane,
    output logic signed [PSW-1:0]   psum
);
    always_comb begin
        psum = '0;
        for (int k = 0; k < TAPS; k++)
            if (taps[k][plane])
                psum = psum + PSW'($signed(coefs[k]));
    end
endmodule

// File: rtl/fda_fir.sv
module fda_fir #(
    parameter int TAPS  = 16,
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int GUARD = 4,
    localparam int AW   = $clog2(TAPS),
    localparam int PW   = $clog2(DW),
    localparam int PSW  = CW + AW + 1,
    localparam int ACCW = PSW + GUARD + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_sample,
    input  logic          coef_we,
    input  logic [AW-1:0] coef_addr,
    input  logic [CW-1:0] coef_data,
    output logic          out_valid,
    output logic [DW-1:0] out_sample
);
    import fda_pkg::*;

    localparam logic signed [ACCW-1:0] HALF = ACCW'(2 ** (GUARD - 1));
    localparam logic signed [ACCW-1:0] MAXV = ACCW'(2 ** (DW - 1) - 1);
    localparam logic signed [ACCW-1:0] MINV = -ACCW'(2 ** (DW - 1));

    fda_state_t state, nxt;
    logic                    busy, accept, last_plane;
    logic [PW-1:0]           plane;
    logic signed [ACCW-1:0]  acc, acc_next, ps_ext, rnd, scaled;
    logic signed [PSW-1:0]   psum;
    logic [DW-1:0]           sat_val;
    logic [TAPS-1:0][DW-1:0] taps;
    logic [TAPS-1:0][CW-1:0] active;

    assign busy       = (state != ST_IDLE);
    assign accept     = !busy && in_valid;
    assign last_plane = (plane == PW'(DW - 1));

    fda_delay_line #(.TAPS(TAPS), .DW(DW)) u_line (
        .clk(clk), .rst_n(rst_n), .shift_en(accept), .din(in_sample), .taps(taps)
    );

    fda_coef_bank #(.TAPS(TAPS), .CW(CW)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(coef_we), .waddr(coef_addr),
        .wdata(coef_data), .commit(accept), .active(active)
    );

    fda_plane_sum #(.TAPS(TAPS), .DW(DW), .CW(CW)) u_psum (
        .taps(taps), .coefs(active), .plane(plane), .psum(psum)
    );

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  nxt = accept ? ST_PLANE : ST_IDLE;
            ST_PLANE: nxt = last_plane ? ST_EMIT : ST_PLANE;
            ST_EMIT:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Plane accumulation: magnitude planes add then halve, sign plane subtracts
    assign ps_ext   = {{(ACCW - PSW - GUARD){psum[PSW-1]}}, psum, {GUARD{1'b0}}};
    assign acc_next = last_plane ? (acc - ps_ext) : ((acc + ps_ext) >>> 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            plane <= '0;
        end else if (accept) begin
            acc   <= '0;
            plane <= '0;
        end else if (state == ST_PLANE) begin
            acc   <= acc_next;
            plane <= plane + 1'b1;
        end
    end

    // Round half up, then saturate
    assign rnd    = acc + HALF;
    assign scaled = rnd >>> GUARD;
    always_comb begin
        if (scaled > MAXV)      sat_val = MAXV[DW-1:0];
        else if (scaled < MINV) sat_val = MINV[DW-1:0];
        else                    sat_val = scaled[DW-1:0];
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= (state == ST_EMIT);
            if (state == ST_EMIT)
                out_sample <= sat_val;
        end
    end
endmodule

// File: rtl/fda_fir_chk.sv
module fda_fir_chk #(
    parameter int TAPS = 16,
    parameter int DW   = 16,
    parameter int CW   = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    busy,
    input logic                    out_valid,
    input logic [DW-1:0]           out_sample,
    input logic [TAPS-1:0][DW-1:0] taps,
    input logic [TAPS-1:0][CW-1:0] active
);
    logic [4:0] since;
    logic       running;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since   <= '0;
            running <= 1'b0;
        end else if (!busy && in_valid) begin
            since   <= '0;
            running <= 1'b1;
        end else if (running && since != 5'd31) begin
            since <= since + 1'b1;
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);                                    // R6
    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (running && since == 5'd17));                   // R6
    AST_BUSY_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(taps));                                      // R7
    AST_COEF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(active));                                    // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_sample) |-> out_valid);                          // R9
endmodule

bind fda_fir fda_fir_chk #(.TAPS(TAPS), .DW(DW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .busy(busy),
    .out_valid(out_valid), .out_sample(out_sample), .taps(taps), .active(active)
);

// File: tb/fda_fir_tb.sv
module fda_fir_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst_n = 0;
    logic        in_valid = 0, coef_we = 0;
    logic [15:0] in_sample = '0, coef_data = '0;
    logic [3:0]  coef_addr = '0;
    logic        out_valid;
    logic [15:0] out_sample;

    int n_checks = 0, n_fail = 0;
    bit done = 0;
    int pend[16], act[16], hist[16];
    logic [31:0] lcg = 32'h1234_5678;

    fda_fir u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input int got, input int exp_v);
        n_checks++;
        if (got != exp_v) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, got, exp_v);
        end
    endtask

    function automatic int model();
        longint a = 0;
        for (int j = 0; j < 16; j++) begin
            longint p = 0;
            for (int k = 0; k < 16; k++) begin
                logic [15:0] hb = hist[k][15:0];
                if (hb[j]) p += act[k];
            end
            if (j < 15) a = (a + 16 * p) >>> 1;
            else        a = a - 16 * p;
        end
        a = (a + 8) >>> 4;
        if (a > 32767)  a = 32767;
        if (a < -32768) a = -32768;
        return int'(a);
    endfunction

    function automatic int rnd16();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return int'($signed(lcg[30:15]));
    endfunction

    task automatic wr_coef(input int a, input int d);
        @(negedge clk);
        coef_we = 1; coef_addr = a[3:0]; coef_data = d[15:0];
        @(posedge clk);
        @(negedge clk);
        coef_we = 0;
        pend[a] = d;
    endtask

    task automatic send(input int x, input string req,
                        input bit same_we, input int sa, input int sd,
                        input bit mid_we, input int ma, input int md,
                        input bit flood, input int fx);
        int exp_v, cnt;
        for (int k = 15; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        for (int k = 0; k < 16; k++) act[k] = pend[k];
        exp_v = model();
        if (same_we) pend[sa] = sd;
        @(negedge clk);
        in_valid = 1; in_sample = x[15:0];
        if (same_we) begin coef_we = 1; coef_addr = sa[3:0]; coef_data = sd[15:0]; end
        @(posedge clk);
        @(negedge clk);
        in_valid = flood; in_sample = fx[15:0]; coef_we = 0;
        cnt = 0;
        while (!out_valid && cnt < 40) begin
            if (mid_we && cnt == 5) begin
                coef_we = 1; coef_addr = ma[3:0]; coef_data = md[15:0];
                pend[ma] = md;
            end else coef_we = 0;
            @(posedge clk);
            cnt++;
            @(negedge clk);
        end
        in_valid = 0; coef_we = 0;
        chk("R6 latency", cnt, 17);
        chk(req, int'($signed(out_sample)), exp_v);
        @(posedge clk);
        @(negedge clk);
        chk("R6 single pulse", int'(out_valid), 0);
    endtask

    task automatic plain(input int x, input string req);
        send(x, req, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        chk("R1 valid after reset", int'(out_valid), 0);
        chk("R1 output after reset", int'(out_sample), 0);
        plain(12345, "R1 zero coefficients");
    endtask

    task automatic t_impulse();
        for (int k = 0; k < 16; k++) wr_coef(k, (k + 1) * 1500 - 12000);
        plain(32767, "R2 impulse tap 0");
        for (int k = 1; k < 16; k++) plain(0, "R2 impulse tail");
    endtask

    task automatic t_mixed();
        for (int k = 0; k < 16; k++) wr_coef(k, rnd16() / 4);
        for (int i = 0; i < 20; i++) begin
            int x = rnd16();
            plain(x, (x < 0) ? "R3 negative sample" : "R3 positive sample");
        end
        plain(-32768, "R3 most negative sample");
    endtask

    task automatic t_round();
        wr_coef(0, 1);
        for (int k = 1; k < 16; k++) wr_coef(k, 0);
        plain(16384, "R4 plus half");
        plain(-16384, "R4 minus half");
        plain(8192, "R4 quarter");
        plain(24576, "R4 three quarters");
        plain(-24576, "R4 minus three quarters");
    endtask

    task automatic t_sat();
        for (int k = 0; k < 16; k++) wr_coef(k, 32767);
        for (int i = 0; i < 16; i++) plain(-32768, "R5 negative saturation");
        chk("R5 negative rail", int'($signed(out_sample)), -32768);
        for (int k = 0; k < 16; k++) wr_coef(k, -32768);
        plain(-32768, "R5 positive saturation");
        chk("R5 positive rail", int'($signed(out_sample)), 32767);
    endtask

    task automatic t_busy();
        for (int k = 0; k < 16; k++) wr_coef(k, 1000 * (k + 1));
        send(4000, "R7 flooded sample", 0, 0, 0, 0, 0, 0, 1, 31000);
        plain(-2500, "R7 ignored sample absent from history");
    endtask

    task automatic t_coef_timing();
        send(7000, "R8 write at accepting edge", 1, 0, -20000, 0, 0, 0, 0, 0);
        send(-9000, "R8 write during computation", 0, 0, 0, 1, 1, 15000, 0, 0);
        plain(3000, "R8 both writes applied");
    endtask

    task automatic t_hold();
        int held;
        plain(11111, "R9 fresh result");
        held = int'(out_sample);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R9 output holds", int'(out_sample), held);
            chk("R9 no stray valid", int'(out_valid), 0);
        end
    endtask

    initial begin
        for (int k = 0; k < 16; k++) begin pend[k] = 0; act[k] = 0; hist[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_impulse();
        t_mixed();
        t_round();
        t_sat();
        t_busy();
        t_coef_timing();
        t_hold();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule